// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test access port that sits beside a device core. A four-wire test interface (test clock, mode select, serial input, serial output with its own output enable) plus an optional asynchronous active-low reset steps a sixteen-state controller. The controller moves serial data through one of three shift paths. These are a three-bit instruction path, a one-stage bypass stage, and a 118-cell boundary chain that wraps the core's pins.

The instruction that is in force picks the data path and the test mode. EXTEST and SAMPLE/PRELOAD both place the boundary chain between input and output. BYPASS shortens the path to a single stage. On the core side, each boundary cell takes a parallel capture bit from the pin and returns a parallel update bit from its own latch. A separate flag tells the core to drive its pins from those update bits while EXTEST is in force.

Input sampling and state changes happen on the rising test-clock edge. The serial output, its enable and the parallel latches change on the falling edge. This lets a tester capture the output on the next rising edge without a hold-time race.

Top module: `bscan_tap`

## Requirements
- R1: The controller follows the standard sixteen-state test-access state graph on each rising edge of `test_clk`, steered by `mode_sel`. Five consecutive rising edges with `mode_sel` high reach Test-Logic-Reset from any state. At the next falling edge in that state, the instruction latch loads the bypass code 3'b111.
- R2: Driving `test_rst_n` low takes effect at once, without a clock. It places the controller in Test-Logic-Reset and sets the instruction latch to 3'b111. It also clears every update latch to 0, so that all active-high three-state enable cells turn their drivers off, and it forces `scan_oe` and `core_drive` low.
- R3: In Capture-IR the instruction shift stages load 3'b001. In Shift-IR they shift toward `scan_out` with bit 0 first, and `scan_in` enters bit 2. They shift in no other state. The falling edge in Update-IR copies them into the instruction latch.
- R4: Instruction codes 3'b000 and 3'b001 mean EXTEST, codes 3'b010 through 3'b101 mean SAMPLE/PRELOAD, and codes 3'b110 and 3'b111 mean BYPASS. The first two instructions select the boundary chain and the third selects the bypass stage.
- R5: With BYPASS in force, the bypass stage captures 0 in Capture-DR. In Shift-DR, `scan_out` then gives that 0 followed by `scan_in` delayed by one clock.
- R6: With a boundary instruction in force, Capture-DR loads all 118 cells from `core_capture`. Shift-DR presents cell 0 first on `scan_out` and feeds `scan_in` into cell 117, so 118 shifts leave cell i holding the i-th bit shifted in.
- R7: The falling edge in Update-DR copies the boundary cells onto `core_update`, but only when a boundary instruction is in force. Under BYPASS, `core_update` keeps its value. `core_update` never changes on a rising edge.
- R8: `scan_out` and `scan_oe` change only on falling edges of `test_clk`. `scan_oe` is high exactly while the controller is in Shift-IR or Shift-DR. In every other state, including Run-Test/Idle and Pause-DR, it is low.
- R9: `core_drive` is high exactly while the instruction latch holds an EXTEST code. It rises only at the falling edge in Update-IR.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| test_clk | input | 1 | Test clock |
| test_rst_n | input | 1 | Asynchronous active-low reset of the test logic |
| mode_sel | input | 1 | State-steering input, sampled on the rising edge |
| scan_in | input | 1 | Serial data input, sampled on the rising edge |
| scan_out | output | 1 | Serial data output, updated on the falling edge |
| scan_oe | output | 1 | Output enable for `scan_out` (low means high impedance) |
| core_capture | input | 118 | Parallel pin values loaded into the boundary cells in Capture-DR |
| core_update | output | 118 | Parallel update latches of the boundary cells |
| core_drive | output | 1 | Core drives its pins from `core_update` (EXTEST in force) |

## Verification
Most faults in the controller state register appear at the port within one or two test clocks. A wrong state shows up as `scan_oe` rising or falling half a clock off, or as a lost or extra bit in the serial stream. A wrong instruction latch is visible at the next scan. It changes the data path's length, which the bench sees as a one-bit offset against 118 bits, and it can flip `core_drive` one falling edge after Update-IR. A corrupted boundary cell stays hidden until the next Update-DR or scan-out. For that reason every boundary scan is checked bit for bit, both on `scan_out` and on `core_update` afterwards.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  localparam int IR_W = 3;

  localparam logic [IR_W-1:0] IR_CAPTURE_PAT   = 3'b001;
  localparam logic [IR_W-1:0] IR_RESET_CODE    = 3'b111;
  localparam logic [IR_W-1:0] IR_FIRST_SAMPLE  = 3'b010;
  localparam logic [IR_W-1:0] IR_FIRST_BYPASS  = 3'b110;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {
    OP_EXTEST, OP_SAMPLE, OP_BYPASS
  } tap_op_e;

  // Controller transition for one rising edge.
  function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
    tap_state_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: n = m ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: n = m ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

  // Instruction decode: codes are ordered so two thresholds split them.
  function automatic tap_op_e tap_decode(input logic [IR_W-1:0] code);
    if (code < IR_FIRST_SAMPLE)      return OP_EXTEST;
    else if (code < IR_FIRST_BYPASS) return OP_SAMPLE;
    else                             return OP_BYPASS;
  endfunction

endpackage

// File: rtl/bscan_fsm.sv
module bscan_fsm
  import bscan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_sel,
  output tap_state_e state_q,
  output logic       in_reset,
  output logic       cap_ir,
  output logic       shf_ir,
  output logic       upd_ir,
  output logic       cap_dr,
  output logic       shf_dr,
  output logic       upd_dr
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RESET;
    else        state_q <= tap_next(state_q, mode_sel);
  end

  assign in_reset = (state_q == ST_RESET);
  assign cap_ir   = (state_q == ST_CAP_IR);
  assign shf_ir   = (state_q == ST_SHF_IR);
  assign upd_ir   = (state_q == ST_UPD_IR);
  assign cap_dr   = (state_q == ST_CAP_DR);
  assign shf_dr   = (state_q == ST_SHF_DR);
  assign upd_dr   = (state_q == ST_UPD_DR);

endmodule

// File: rtl/bscan_ir.sv
module bscan_ir
  import bscan_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_reset,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            scan_in,
  output logic [IR_W-1:0] shift_q,
  output logic [IR_W-1:0] code_q
);

  // Shift stages: rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       shift_q <= '0;
    else if (capture) shift_q <= IR_CAPTURE_PAT;
    else if (shift)   shift_q <= {scan_in, shift_q[IR_W-1:1]};
  end

  // Parallel latch: falling edge.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)        code_q <= IR_RESET_CODE;
    else if (in_reset) code_q <= IR_RESET_CODE;
    else if (update)   code_q <= shift_q;
  end

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr #(
  parameter int CELLS = 118
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_bypass,
  input  logic             capture,
  input  logic             shift,
  input  logic             update,
  input  logic             scan_in,
  input  logic [CELLS-1:0] core_capture,
  output logic             bypass_q,
  output logic [CELLS-1:0] chain_q,
  output logic [CELLS-1:0] update_q
);

  logic bnd_cap, bnd_shf, bnd_upd;
  assign bnd_cap = capture & ~sel_bypass;
  assign bnd_shf = shift   & ~sel_bypass;
  assign bnd_upd = update  & ~sel_bypass;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    bypass_q <= 1'b0;
    else if (capture & sel_bypass) bypass_q <= 1'b0;
    else if (shift & sel_bypass)   bypass_q <= scan_in;
  end

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    logic nxt, sh_q, up_q;

    if (i == CELLS - 1) begin : g_head
      assign nxt = scan_in;
    end else begin : g_body
      assign nxt = chain_q[i+1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sh_q <= 1'b0;
      else if (bnd_cap) sh_q <= core_capture[i];
      else if (bnd_shf) sh_q <= nxt;
    end

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)       up_q <= 1'b0;
      else if (bnd_upd) up_q <= sh_q;
    end

    assign chain_q[i]  = sh_q;
    assign update_q[i] = up_q;
  end

endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
  import bscan_pkg::*;
#(
  parameter int CELLS = 118
) (
  input  logic             test_clk,
  input  logic             test_rst_n,
  input  logic             mode_sel,
  input  logic             scan_in,
  output logic             scan_out,
  output logic             scan_oe,
  input  logic [CELLS-1:0] core_capture,
  output logic [CELLS-1:0] core_update,
  output logic             core_drive
);

  tap_state_e      state_q;
  logic            in_reset, cap_ir, shf_ir, upd_ir, cap_dr, shf_dr, upd_dr;
  logic [IR_W-1:0] ir_shift, ir_code;
  tap_op_e         op_now;
  logic            sel_bypass;
  logic            bypass_q;
  logic [CELLS-1:0] chain_q;
  logic            out_next, shifting;

  bscan_fsm u_fsm (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .mode_sel (mode_sel),
    .state_q  (state_q),
    .in_reset (in_reset),
    .cap_ir   (cap_ir),
    .shf_ir   (shf_ir),
    .upd_ir   (upd_ir),
    .cap_dr   (cap_dr),
    .shf_dr   (shf_dr),
    .upd_dr   (upd_dr)
  );

  bscan_ir u_ir (
    .clk      (test_clk),
    .rst_n    (test_rst_n),
    .in_reset (in_reset),
    .capture  (cap_ir),
    .shift    (shf_ir),
    .update   (upd_ir),
    .scan_in  (scan_in),
    .shift_q  (ir_shift),
    .code_q   (ir_code)
  );

  assign op_now     = tap_decode(ir_code);
  assign sel_bypass = (op_now == OP_BYPASS);
  assign core_drive = (op_now == OP_EXTEST);

  bscan_dr #(.CELLS(CELLS)) u_dr (
    .clk          (test_clk),
    .rst_n        (test_rst_n),
    .sel_bypass   (sel_bypass),
    .capture      (cap_dr),
    .shift        (shf_dr),
    .update       (upd_dr),
    .scan_in      (scan_in),
    .core_capture (core_capture),
    .bypass_q     (bypass_q),
    .chain_q      (chain_q),
    .update_q     (core_update)
  );

  // Serial output path selection.
  assign shifting = shf_ir | shf_dr;
  always_comb begin
    if (shf_ir)          out_next = ir_shift[0];
    else if (!shf_dr)    out_next = 1'b0;
    else if (sel_bypass) out_next = bypass_q;
    else                 out_next = chain_q[0];
  end

  always_ff @(negedge test_clk or negedge test_rst_n) begin
    if (!test_rst_n) begin
      scan_out <= 1'b0;
      scan_oe  <= 1'b0;
    end else begin
      scan_out <= out_next;
      scan_oe  <= shifting;
    end
  end

endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
  import bscan_pkg::*;
#(
  parameter int CELLS = 118
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_sel,
  input tap_state_e       state_q,
  input logic [IR_W-1:0]  ir_shift,
  input logic             bypass_q,
  input logic             sel_bypass,
  input logic             scan_oe,
  input logic             core_drive,
  input logic [CELLS-1:0] core_update
);

  logic [2:0] high_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              high_run <= '0;
    else if (!mode_sel)      high_run <= '0;
    else if (high_run != 3'd7) high_run <= high_run + 3'd1;
  end

  // R1
  five_high_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (high_run >= 3'd5) |-> (state_q == ST_RESET));

  // R3
  ir_capture_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAP_IR) |=> (ir_shift == IR_CAPTURE_PAT));

  // R5
  bypass_capture_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CAP_DR && sel_bypass) |=> !bypass_q);

  // R7
  update_only_in_upd_dr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_update) |-> (state_q == ST_UPD_DR));

  // R8
  oe_only_shifting_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_oe |-> (state_q == ST_SHF_IR || state_q == ST_SHF_DR));

  // R9
  drive_rise_in_upd_ir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_drive) |-> (state_q == ST_UPD_IR));

endmodule

bind bscan_tap bscan_tap_chk #(.CELLS(CELLS)) u_chk (
  .clk         (test_clk),
  .rst_n       (test_rst_n),
  .mode_sel    (mode_sel),
  .state_q     (state_q),
  .ir_shift    (ir_shift),
  .bypass_q    (bypass_q),
  .sel_bypass  (sel_bypass),
  .scan_oe     (scan_oe),
  .core_drive  (core_drive),
  .core_update (core_update)
);

// File: tb/bscan_tap_bench.sv
module bscan_tap_bench;

  localparam int N = 118;

  logic         test_clk = 1'b0;
  logic         test_rst_n = 1'b0;
  logic         mode_sel = 1'b1;
  logic         scan_in = 1'b1;
  logic         scan_out, scan_oe, core_drive;
  logic [N-1:0] core_capture = '0;
  logic [N-1:0] core_update;

  int vectors = 0;
  int fails = 0;
  logic [N-1:0] upd_exp = '0;

  bscan_tap #(.CELLS(N)) u_bscan_tap (
    .test_clk     (test_clk),
    .test_rst_n   (test_rst_n),
    .mode_sel     (mode_sel),
    .scan_in      (scan_in),
    .scan_out     (scan_out),
    .scan_oe      (scan_oe),
    .core_capture (core_capture),
    .core_update  (core_update),
    .core_drive   (core_drive)
  );

  always #5 test_clk = ~test_clk;

  task automatic check(input string req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] pat(input logic [31:0] seed);
    logic [127:0] w;
    w = {seed * 32'h9E37_79B9, ~seed, seed ^ 32'h5A5A_C3C3, seed[15:0], 16'hB00F};
    return w[N-1:0];
  endfunction

  // One test clock: read outputs after the falling edge, then drive inputs
  // for the following rising edge.
  task automatic step(input logic m, input logic d, output logic o, output logic oe);
    @(negedge test_clk); #1;
    o = scan_out; oe = scan_oe;
    mode_sel = m; scan_in = d;
  endtask

  task automatic go(input logic m);
    logic o, oe;
    step(m, 1'b0, o, oe);
  endtask

  // From Run-Test/Idle back to Run-Test/Idle.
  task automatic load_ir(input logic [2:0] code, output logic [2:0] seen, output logic all_oe);
    logic o, oe;
    all_oe = 1'b1;
    go(1); go(1); go(0); go(0);
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i], o, oe);
      seen[i] = o; all_oe &= oe;
    end
    go(1); go(0);
  endtask

  task automatic scan_dr(input logic [N-1:0] din, output logic [N-1:0] dout, output logic all_oe);
    logic o, oe;
    all_oe = 1'b1;
    go(1); go(0); go(0);
    for (int i = 0; i < N; i++) begin
      step(i == N - 1, din[i], o, oe);
      dout[i] = o; all_oe &= oe;
    end
    go(1); go(0);
  endtask

  task automatic bypass_expect(input string req, input string what);
    logic [N-1:0] din, dout;
    logic aoe;
    din = pat(32'h77);
    scan_dr(din, dout, aoe);
    check(req, what, dout, {din[N-2:0], 1'b0});
    check("R7", "core_update unchanged under bypass", core_update, upd_exp);
  endtask

  task automatic t_reset_state();
    test_rst_n = 1'b0; mode_sel = 1'b1;
    repeat (3) @(negedge test_clk);
    #1 test_rst_n = 1'b1;
    upd_exp = '0;
    check("R2", "scan_oe after reset", N'(scan_oe), N'(1'b0));
    check("R2", "core_update cleared (enables off)", core_update, '0);
    check("R2", "core_drive after reset", N'(core_drive), N'(1'b0));
    go(0);
    bypass_expect("R2", "reset instruction is bypass");
  endtask

  task automatic t_ir_capture();
    logic [2:0] seen; logic aoe;
    load_ir(3'b010, seen, aoe);
    check("R3", "capture-IR pattern out", N'(seen), N'(3'b001));
    check("R8", "scan_oe during Shift-IR", N'(aoe), N'(1'b1));
  endtask

  task automatic t_boundary(input logic [2:0] code);
    logic [2:0] seen; logic aoe;
    logic [N-1:0] din, dout;
    core_capture = pat({29'd0, code} + 32'h100);
    din = pat({29'd0, code} + 32'h200);
    load_ir(code, seen, aoe);
    check("R9", "core_drive for code", N'(core_drive), N'(code < 3'b010));
    scan_dr(din, dout, aoe);
    check("R6", "boundary capture out, bit 0 first", dout, core_capture);
    check("R8", "scan_oe during Shift-DR", N'(aoe), N'(1'b1));
    upd_exp = din;
    check("R4", "boundary selected, update holds shifted data", core_update, upd_exp);
  endtask

  task automatic t_bypass(input logic [2:0] code);
    logic [2:0] seen; logic aoe;
    load_ir(code, seen, aoe);
    check("R4", "bypass code drops core_drive", N'(core_drive), N'(1'b0));
    bypass_expect("R5", "bypass one-stage path");
  endtask

  task automatic t_update_edge();
    logic [2:0] seen; logic aoe;
    logic [N-1:0] din;
    logic o, oe;
    load_ir(3'b011, seen, aoe);
    din = pat(32'hABCD);
    go(1); go(0); go(0);
    for (int i = 0; i < N; i++) step(i == N - 1, din[i], o, oe);
    go(1);
    @(posedge test_clk); #1;
    check("R7", "no update on rising edge", core_update, upd_exp);
    @(negedge test_clk); #1;
    upd_exp = din;
    check("R7", "update on falling edge", core_update, upd_exp);
    mode_sel = 1'b0;
  endtask

  task automatic t_pause_oe();
    logic o, oe;
    step(0, 0, o, oe);
    check("R8", "scan_oe low in Run-Test/Idle", N'(oe), N'(1'b0));
    go(1); go(0); go(0);
    step(0, 0, o, oe);
    go(1); go(0);
    step(0, 0, o, oe);
    step(1, 0, o, oe);
    check("R8", "scan_oe low in Pause-DR", N'(oe), N'(1'b0));
    go(0);
    step(1, 0, o, oe);
    check("R8", "scan_oe high again in Shift-DR", N'(oe), N'(1'b1));
    go(1); go(0);
  endtask

  task automatic t_tms_reset();
    logic [2:0] seen; logic aoe;
    core_capture = pat(32'h4242);
    load_ir(3'b000, seen, aoe);
    check("R9", "EXTEST loaded", N'(core_drive), N'(1'b1));
    go(1); go(0); go(0);
    step(0, 1'b1, seen[0], aoe);
    for (int i = 0; i < 5; i++) step(1, 1'b0, seen[0], aoe);
    go(1);
    check("R1", "five high clocks reset instruction", N'(core_drive), N'(1'b0));
    upd_exp = {1'b0, 1'b1, core_capture[N-1:2]};
    check("R1", "update passed on the way to reset", core_update, upd_exp);
    go(0);
    bypass_expect("R1", "bypass after reset by mode_sel");
  endtask

  task automatic t_async_reset();
    logic [2:0] seen; logic aoe;
    load_ir(3'b001, seen, aoe);
    go(1); go(0); go(0);
    step(0, 1'b1, seen[0], aoe);
    @(negedge test_clk); #3;
    test_rst_n = 1'b0;
    #1;
    upd_exp = '0;
    check("R2", "async reset drops core_drive", N'(core_drive), N'(1'b0));
    check("R2", "async reset drops scan_oe", N'(scan_oe), N'(1'b0));
    check("R2", "async reset clears update", core_update, '0);
    @(negedge test_clk); #1;
    mode_sel = 1'b1; test_rst_n = 1'b1;
    go(0);
    bypass_expect("R2", "bypass after async reset");
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ir_capture();
    for (int c = 2; c <= 5; c++) t_boundary(3'(c));
    for (int c = 0; c <= 1; c++) t_boundary(3'(c));
    for (int c = 6; c <= 7; c++) t_bypass(3'(c));
    t_update_edge();
    t_pause_oe();
    t_tms_reset();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule